// File: doc/BRIEF.md
# Interrupt status aggregator

This block collects interrupt events from the link side of a PCIe root port and folds them into a three-level tree of status registers. The first level has two registers. One records MSI arrival and legacy INTx assert and deassert events. The other records INTx asserts, power-state changes and flush requests. A separate 32-vector MSI status register sits beside them, together with a per-vector mask and a capture of the low byte of the last MSI payload. Each status register has a companion mask, where a 1 suppresses the source. The effective pending set at each level is status AND NOT mask, limited to that level's valid bits.

Any unmasked pending bit at the first level sets a core summary bit in a top-level status register. That register also has a mask, and its unmasked bits drive one registered interrupt line. Every status register is write-1-to-clear through a simple register bus. Writes take a write port, and reads are combinational on a separate read address. Software services the line by reading down the tree and clearing each level from the bottom up.

Top module: `irq_status_tree`

## Requirements
- R1: After reset all status registers and the payload capture read 0, and `irq_o` is 0. The first-level mask reads 0x06FFFFFF, so only the MSI summary bit 24 is unmasked. The second-level mask reads 0x00000FF0, the MSI vector mask reads 0 and the top mask reads 0x00FEF0FB, so the core bit 16 is unmasked. Word addresses are: 0 status A, 1 mask A, 2 status B, 3 mask B, 4 MSI status, 5 MSI mask, 6 payload, 7 top status, 8 top mask. Any other address reads 0.
- R2: A one-cycle pulse on `intx_assert_i[n]` sets status A bit 16+n and status B bit 8+n. A pulse on `intx_deassert_i[n]` sets status A bit 20+n. `pm_change_i` sets status B bit 4 and `flush_i` sets status B bit 5. Each bit reads as set in the cycle after the clock edge that sampled the event.
- R3: An MSI event sets MSI status bit `msi_vec_i` and loads `msi_data_i` into payload bits 7:0. The payload holds its value until the next event. Status A bit 24 is set only if that vector's bit in the MSI mask is 0.
- R4: A write to a status register clears exactly the bits written as 1, and bits written as 0 keep their value. An event that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R5: Mask writes keep only the valid bits: 26:0 for mask A, 11:4 for mask B and 0x00FFF0FB for the top mask. Status registers hold only bits that have a source.
- R6: Top status bit 16 is set one cycle after status A & ~mask A & 0x07FFFFFF or status B & ~mask B & 0xFF0 becomes non-zero. Masked pending bits never set it.
- R7: Clearing top bit 16 has no effect while an unmasked first-level bit is still pending. The bit clears once the lower level has been cleared one cycle earlier.
- R8: `irq_o` is registered. It equals the OR of top status & ~top mask & 0x00FFF0FB as that value stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| intx_assert_i | input | 4 | INTx assert event pulses |
| intx_deassert_i | input | 4 | INTx deassert event pulses |
| pm_change_i | input | 1 | Power-state change event pulse |
| flush_i | input | 1 | Flush event pulse |
| msi_evt_i | input | 1 | MSI received pulse |
| msi_vec_i | input | 5 | MSI vector number |
| msi_data_i | input | 8 | Low byte of the MSI payload |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Event and write effects on the status, mask and payload registers are due one edge after the sampling edge. The top summary bit follows one edge later, and `irq_o` one edge after that. The bench therefore queues its expectations stage by stage, right after each edge. The monitor compares them at the following falling edge. This makes the two-edge and three-edge delays, and the same-edge race between a clear and an event, visible cycle by cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_STAT1  = 4'd0;
  localparam logic [AW-1:0] A_MASK1  = 4'd1;
  localparam logic [AW-1:0] A_STAT2  = 4'd2;
  localparam logic [AW-1:0] A_MASK2  = 4'd3;
  localparam logic [AW-1:0] A_MSIST  = 4'd4;
  localparam logic [AW-1:0] A_MSIMK  = 4'd5;
  localparam logic [AW-1:0] A_PAYLD  = 4'd6;
  localparam logic [AW-1:0] A_TOPST  = 4'd7;
  localparam logic [AW-1:0] A_TOPMK  = 4'd8;

  localparam int L1_ASSERT_LSB   = 16;
  localparam int L1_DEASSERT_LSB = 20;
  localparam int L1_MSI_BIT      = 24;
  localparam int L2_PM_BIT       = 4;
  localparam int L2_FLUSH_BIT    = 5;
  localparam int L2_ASSERT_LSB   = 8;
  localparam int TOP_CORE_BIT    = 16;

  localparam logic [DW-1:0] L1_PEND_VALID = 32'h07FF_FFFF;
  localparam logic [DW-1:0] L2_PEND_VALID = 32'h0000_0FF0;
  localparam logic [DW-1:0] TOP_VALID     = 32'h00FF_F0FB;

  localparam logic [DW-1:0] L1_MASK_RST  = L1_PEND_VALID & ~(32'h1 << L1_MSI_BIT);
  localparam logic [DW-1:0] L2_MASK_RST  = L2_PEND_VALID;
  localparam logic [DW-1:0] TOP_MASK_RST = TOP_VALID & ~(32'h1 << TOP_CORE_BIT);
endpackage

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en_i ? clr_i : '0;
    q_d     = ((q_o & ~clr_eff) | set_i) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // R4: a source event always lands, even against a same-cycle clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & VALID)) |=> ((q_o & $past(set_i & VALID)) == $past(set_i & VALID)));

  // R4: cleared bits with no concurrent event read back as zero
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && |(clr_i & ~set_i & q_o)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] VALID   = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wen_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wen_i) q_d = d_i & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL & VALID;
    else        q_o <= q_d;
  end

  // R5: a write stores exactly the valid subset of the data
  p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wen_i |=> (q_o == ($past(d_i) & VALID)));
endmodule

// File: rtl/msi_capture.sv
module msi_capture #(
  parameter int VEC_N = 32,
  parameter int PAY_W = 8,
  localparam int VEC_W = $clog2(VEC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [PAY_W-1:0] data_i,
  input  logic [VEC_N-1:0] vec_mask_i,
  output logic [VEC_N-1:0] vec_set_o,
  output logic             hit_o,
  output logic [PAY_W-1:0] payload_o
);
  logic [PAY_W-1:0] payload_d;

  always_comb begin
    vec_set_o = '0;
    for (int v = 0; v < VEC_N; v++) begin
      vec_set_o[v] = evt_i && (vec_i == VEC_W'(v));
    end
    hit_o     = |(vec_set_o & ~vec_mask_i);
    payload_d = evt_i ? data_i : payload_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) payload_o <= '0;
    else        payload_o <= payload_d;
  end

  // R3: payload captured on every event
  p_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (payload_o == $past(data_i)));

  // R3: payload stable without an event
  p_payload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> $stable(payload_o));
endmodule

// File: rtl/irq_status_tree.sv
module irq_status_tree
  import irqagg_pkg::*;
#(
  parameter int INTX_N    = 4,
  parameter int MSI_VEC_N = 32,
  parameter int PAY_W     = 8,
  localparam int VEC_W    = $clog2(MSI_VEC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [INTX_N-1:0] intx_assert_i,
  input  logic [INTX_N-1:0] intx_deassert_i,
  input  logic             pm_change_i,
  input  logic             flush_i,
  input  logic             msi_evt_i,
  input  logic [VEC_W-1:0] msi_vec_i,
  input  logic [PAY_W-1:0] msi_data_i,
  output logic             irq_o
);
  function automatic logic [DW-1:0] l1_store_bits();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < INTX_N; n++) begin
      m[L1_ASSERT_LSB+n]   = 1'b1;
      m[L1_DEASSERT_LSB+n] = 1'b1;
    end
    m[L1_MSI_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] l2_store_bits();
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < INTX_N; n++) m[L2_ASSERT_LSB+n] = 1'b1;
    m[L2_PM_BIT]    = 1'b1;
    m[L2_FLUSH_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] L1_STORE  = l1_store_bits();
  localparam logic [DW-1:0] L2_STORE  = l2_store_bits();
  localparam logic [DW-1:0] TOP_STORE = DW'(1) << TOP_CORE_BIT;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  // write decode
  logic we_st1, we_mk1, we_st2, we_mk2, we_msist, we_msimk, we_topst, we_topmk;
  always_comb begin
    we_st1   = wr_en && (wr_addr == A_STAT1);
    we_mk1   = wr_en && (wr_addr == A_MASK1);
    we_st2   = wr_en && (wr_addr == A_STAT2);
    we_mk2   = wr_en && (wr_addr == A_MASK2);
    we_msist = wr_en && (wr_addr == A_MSIST);
    we_msimk = wr_en && (wr_addr == A_MSIMK);
    we_topst = wr_en && (wr_addr == A_TOPST);
    we_topmk = wr_en && (wr_addr == A_TOPMK);
  end

  // MSI front end
  logic [MSI_VEC_N-1:0] msi_stat, msi_mask, msi_vec_set;
  logic                 msi_hit;
  logic [PAY_W-1:0]     payload;

  msi_capture #(.VEC_N(MSI_VEC_N), .PAY_W(PAY_W)) u_msi (
    .clk(clk), .rst_n(rst_ok), .evt_i(msi_evt_i), .vec_i(msi_vec_i),
    .data_i(msi_data_i), .vec_mask_i(msi_mask), .vec_set_o(msi_vec_set),
    .hit_o(msi_hit), .payload_o(payload));

  w1c_status_reg #(.W(MSI_VEC_N), .VALID('1)) u_msi_stat (
    .clk(clk), .rst_n(rst_ok), .set_i(msi_vec_set), .clr_en_i(we_msist),
    .clr_i(wr_data[MSI_VEC_N-1:0]), .q_o(msi_stat));

  cfg_mask_reg #(.W(MSI_VEC_N), .VALID('1), .RST_VAL('0)) u_msi_mask (
    .clk(clk), .rst_n(rst_ok), .wen_i(we_msimk),
    .d_i(wr_data[MSI_VEC_N-1:0]), .q_o(msi_mask));

  // first-level sources
  logic [DW-1:0] set_l1, set_l2;
  always_comb begin
    set_l1 = '0;
    set_l2 = '0;
    for (int n = 0; n < INTX_N; n++) begin
      set_l1[L1_ASSERT_LSB+n]   = intx_assert_i[n];
      set_l1[L1_DEASSERT_LSB+n] = intx_deassert_i[n];
      set_l2[L2_ASSERT_LSB+n]   = intx_assert_i[n];
    end
    set_l1[L1_MSI_BIT]   = msi_hit;
    set_l2[L2_PM_BIT]    = pm_change_i;
    set_l2[L2_FLUSH_BIT] = flush_i;
  end

  logic [DW-1:0] stat1, mask1, stat2, mask2, top_stat, top_mask;

  w1c_status_reg #(.W(DW), .VALID(L1_STORE)) u_stat1 (
    .clk(clk), .rst_n(rst_ok), .set_i(set_l1), .clr_en_i(we_st1),
    .clr_i(wr_data), .q_o(stat1));

  cfg_mask_reg #(.W(DW), .VALID(L1_PEND_VALID), .RST_VAL(L1_MASK_RST)) u_mask1 (
    .clk(clk), .rst_n(rst_ok), .wen_i(we_mk1), .d_i(wr_data), .q_o(mask1));

  w1c_status_reg #(.W(DW), .VALID(L2_STORE)) u_stat2 (
    .clk(clk), .rst_n(rst_ok), .set_i(set_l2), .clr_en_i(we_st2),
    .clr_i(wr_data), .q_o(stat2));

  cfg_mask_reg #(.W(DW), .VALID(L2_PEND_VALID), .RST_VAL(L2_MASK_RST)) u_mask2 (
    .clk(clk), .rst_n(rst_ok), .wen_i(we_mk2), .d_i(wr_data), .q_o(mask2));

  // fold into the top level
  logic          pend_any;
  logic [DW-1:0] set_top;
  always_comb begin
    pend_any = (|(stat1 & ~mask1 & L1_PEND_VALID)) ||
               (|(stat2 & ~mask2 & L2_PEND_VALID));
    set_top  = '0;
    set_top[TOP_CORE_BIT] = pend_any;
  end

  w1c_status_reg #(.W(DW), .VALID(TOP_STORE)) u_top_stat (
    .clk(clk), .rst_n(rst_ok), .set_i(set_top), .clr_en_i(we_topst),
    .clr_i(wr_data), .q_o(top_stat));

  cfg_mask_reg #(.W(DW), .VALID(TOP_VALID), .RST_VAL(TOP_MASK_RST)) u_top_mask (
    .clk(clk), .rst_n(rst_ok), .wen_i(we_topmk), .d_i(wr_data), .q_o(top_mask));

  // output line
  logic eff_top, irq_d;
  always_comb begin
    eff_top = |(top_stat & ~top_mask & TOP_VALID);
    irq_d   = eff_top;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

  // read mux
  always_comb begin
    unique case (rd_addr)
      A_STAT1: rd_data = stat1;
      A_MASK1: rd_data = mask1;
      A_STAT2: rd_data = stat2;
      A_MASK2: rd_data = mask2;
      A_MSIST: rd_data = DW'(msi_stat);
      A_MSIMK: rd_data = DW'(msi_mask);
      A_PAYLD: rd_data = DW'(payload);
      A_TOPST: rd_data = top_stat;
      A_TOPMK: rd_data = top_mask;
      default: rd_data = '0;
    endcase
  end

  // R3: an unmasked MSI vector raises the first-level summary
  p_msi_pending_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    msi_hit |=> stat1[L1_MSI_BIT]);

  // R6: the core bit only rises because something unmasked was pending
  p_top_cause_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(top_stat[TOP_CORE_BIT]) |-> $past(pend_any));

  // R7: pending persists, so the core bit cannot be cleared away
  p_top_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    pend_any |=> top_stat[TOP_CORE_BIT]);

  // R8: output line follows the masked top level one cycle later
  p_irq_high_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    eff_top |=> irq_o);
  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !eff_top |=> !irq_o);
endmodule

// File: tb/test_irq_status_tree.sv
`timescale 1ns/100ps
module test_irq_status_tree;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  intx_assert_i, intx_deassert_i;
  logic        pm_change_i, flush_i, msi_evt_i;
  logic [4:0]  msi_vec_i;
  logic [7:0]  msi_data_i;
  logic        irq_o;

  always #5 clk = ~clk;

  irq_status_tree i_irq_status_tree (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .intx_assert_i(intx_assert_i), .intx_deassert_i(intx_deassert_i),
    .pm_change_i(pm_change_i), .flush_i(flush_i), .msi_evt_i(msi_evt_i),
    .msi_vec_i(msi_vec_i), .msi_data_i(msi_data_i), .irq_o(irq_o));

  localparam logic [4:0] IRQ_PIN = 5'd16;

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic expect_at(input logic [4:0] a, input logic [31:0] e, input string t);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // monitor: pops everything queued since the last edge and compares
  initial begin
    rd_addr = '0;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        if (it.addr == IRQ_PIN) begin
          act = {31'b0, irq_o};
        end else begin
          rd_addr = it.addr[3:0];
          #0.2;
          act = rd_data;
        end
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    intx_assert_i = '0; intx_deassert_i = '0; pm_change_i = 1'b0;
    flush_i = 1'b0; msi_evt_i = 1'b0; msi_vec_i = '0; msi_data_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state and map
    expect_at(5'd0, 32'h0, "R1 stat A");
    expect_at(5'd1, 32'h06FF_FFFF, "R1 mask A");
    expect_at(5'd2, 32'h0, "R1 stat B");
    expect_at(5'd3, 32'h0000_0FF0, "R1 mask B");
    expect_at(5'd4, 32'h0, "R1 msi stat");
    expect_at(5'd5, 32'h0, "R1 msi mask");
    expect_at(5'd6, 32'h0, "R1 payload");
    expect_at(5'd7, 32'h0, "R1 top stat");
    expect_at(5'd8, 32'h00FE_F0FB, "R1 top mask");
    expect_at(5'd12, 32'h0, "R1 unmapped");
    expect_at(IRQ_PIN, 32'h0, "R1 irq");
    step();

    // R2 INTx assert 2
    intx_assert_i = 4'b0100;
    step();
    intx_assert_i = '0;
    expect_at(5'd0, 32'h0004_0000, "R2 assert in A");
    expect_at(5'd2, 32'h0000_0400, "R2 assert in B");
    step();
    expect_at(5'd7, 32'h0, "R6 masked no summary");
    step();

    // R2 deassert 1, pm, flush
    intx_deassert_i = 4'b0010; pm_change_i = 1'b1; flush_i = 1'b1;
    step();
    intx_deassert_i = '0; pm_change_i = 1'b0; flush_i = 1'b0;
    expect_at(5'd0, 32'h0024_0000, "R2 deassert in A");
    expect_at(5'd2, 32'h0000_0430, "R2 pm flush in B");
    step();

    // R4 w1c
    reg_write(4'd0, 32'h0004_0000);
    expect_at(5'd0, 32'h0020_0000, "R4 clear one bit");
    step();
    reg_write(4'd2, 32'h0);
    expect_at(5'd2, 32'h0000_0430, "R4 zero write no effect");
    step();

    // R5 mask valid bits
    reg_write(4'd1, 32'hFFFF_FFFF);
    expect_at(5'd1, 32'h07FF_FFFF, "R5 mask A width");
    reg_write(4'd3, 32'hFFFF_FFFF);
    expect_at(5'd3, 32'h0000_0FF0, "R5 mask B width");
    reg_write(4'd8, 32'hFFFF_FFFF);
    expect_at(5'd8, 32'h00FF_F0FB, "R5 top mask width");
    reg_write(4'd1, 32'h06FF_FFFF);
    reg_write(4'd8, 32'h00FE_F0FB);
    reg_write(4'd0, 32'hF800_FFFF);
    expect_at(5'd0, 32'h0020_0000, "R5 stat A sourceless bits");
    step();

    // R3 masked vector
    reg_write(4'd5, 32'h0000_0020);
    msi_evt_i = 1'b1; msi_vec_i = 5'd5; msi_data_i = 8'hA3;
    step();
    msi_evt_i = 1'b0;
    expect_at(5'd4, 32'h0000_0020, "R3 masked vector status");
    expect_at(5'd6, 32'h0000_00A3, "R3 payload");
    expect_at(5'd0, 32'h0020_0000, "R3 masked no summary");
    step(); step();
    expect_at(5'd7, 32'h0, "R6 no top from masked msi");
    step();

    // R3 R6 R8 unmasked vector, timing
    msi_evt_i = 1'b1; msi_vec_i = 5'd31; msi_data_i = 8'h5C;
    step();
    msi_evt_i = 1'b0;
    expect_at(5'd4, 32'h8000_0020, "R3 vector 31");
    expect_at(5'd6, 32'h0000_005C, "R3 payload update");
    expect_at(5'd0, 32'h0120_0000, "R3 summary bit 24");
    expect_at(5'd7, 32'h0, "R6 top not yet");
    expect_at(IRQ_PIN, 32'h0, "R8 irq not yet");
    step();
    expect_at(5'd7, 32'h0001_0000, "R6 top set");
    expect_at(IRQ_PIN, 32'h0, "R8 irq registered");
    step();
    expect_at(IRQ_PIN, 32'h1, "R8 irq high");
    step();

    // R7 sticky top
    reg_write(4'd7, 32'h0001_0000);
    expect_at(5'd7, 32'h0001_0000, "R7 clear ignored while pending");
    reg_write(4'd0, 32'h0100_0000);
    expect_at(5'd0, 32'h0020_0000, "R4 clear msi summary");
    expect_at(5'd7, 32'h0001_0000, "R7 still set same edge");
    reg_write(4'd7, 32'h0001_0000);
    expect_at(5'd7, 32'h0, "R7 cleared");
    expect_at(IRQ_PIN, 32'h1, "R8 irq lags clear");
    step();
    expect_at(IRQ_PIN, 32'h0, "R8 irq low");
    step();

    // R6 R8 unmask deassert bit, then mask top
    reg_write(4'd1, 32'h06DF_FFFF);
    expect_at(5'd7, 32'h0, "R6 top after mask write");
    step();
    expect_at(5'd7, 32'h0001_0000, "R6 unmasked old event");
    step();
    expect_at(IRQ_PIN, 32'h1, "R8 irq from deassert source");
    reg_write(4'd8, 32'h00FF_F0FB);
    expect_at(IRQ_PIN, 32'h1, "R8 irq before mask effect");
    step();
    expect_at(IRQ_PIN, 32'h0, "R8 top mask drops irq");
    expect_at(5'd7, 32'h0001_0000, "R8 top status kept");
    step();

    // R4 collision: event wins over clear
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0001_0000;
    intx_assert_i = 4'b0001;
    step();
    wr_en = 1'b0; wr_data = '0; intx_assert_i = '0;
    expect_at(5'd0, 32'h0021_0000, "R4 event wins");
    expect_at(5'd2, 32'h0000_0530, "R2 assert 0 in B");
    step();

    // R4 msi w1c, R3 payload hold
    reg_write(4'd4, 32'h0000_0020);
    expect_at(5'd4, 32'h8000_0000, "R4 msi vector clear");
    expect_at(5'd6, 32'h0000_005C, "R3 payload held");
    step();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule